// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller collects up to 32 interrupt inputs and presents one active-low request line to a processor. Software programs each input with a trigger type and a 3-bit priority. It turns each input on or off with write-one set and clear commands. The controller picks the best pending, enabled input and pulls the request line low.

The handler reads a vector register. The read returns the winning input number times four, acknowledges the request and records that priority as in service. While a priority is in service, only a strictly higher priority can raise the line again, so handlers nest one level per priority. A write to the end-of-service register retires the innermost level.

A register port with separate read and write strobes, a byte address and 32-bit data gives access to the control registers, the mask commands and several read-only status words. Read data is combinational from the address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every input is disabled, every per-input control register reads 0, the enable word at 0x114 reads 0 and `irq_n` is 1.
- R2: Input i has a control register at byte address 4·i. Bits 7:6 hold the trigger type and bits 2:0 hold the priority, and both read back from the same address.
- R3: A write to 0x120 enables every input whose data bit is 1. A write to 0x124 disables them. Zero bits leave inputs unchanged, 0x114 returns the enable word, and a disabled input never pulls `irq_n` low.
- R4: Priority 7 is the highest and 0 the lowest. When several eligible inputs share the top priority, the lowest input number wins.
- R5: Trigger type 1 makes an input pending while it is high. Trigger type 0 makes it pending while it is low.
- R6: Trigger type 3 latches a pending flag on a rising edge and type 2 on a falling edge. The flag stays set after the input returns and is cleared when that input is acknowledged through the vector read.
- R7: Reading 0x10C returns the winning input number times four, or 0 when nothing is eligible. 0x110 returns the number of the last acknowledged input.
- R8: `irq_n` goes low on the clock edge after an input becomes eligible. It returns high on the clock edge that completes an acknowledging vector read.
- R9: While inputs are in service, only a pending input with a priority strictly above the innermost in-service level is eligible. Any write to 0x130 retires that innermost level.
- R10: 0x100 returns the raw inputs, 0x104 returns the pending word before the enable mask, and 0x108 returns the pending word after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of 0x10C acknowledges |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sets up patterns where several inputs share a priority, so that an arbiter that breaks ties toward the highest input number returns the wrong vector. It raises equal and lower priorities while a handler is in service. A design that compares with "greater or equal", or that drops the whole in-service stack on one end-of-service write, would pull `irq_n` low too early. Edge inputs are pulsed for a single cycle and then checked after the input is gone, which catches a latch that follows the level. The pending word is read again after the acknowledge, which catches a latch that never clears.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int AW   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq_n
);
  localparam int IW   = $clog2(NSRC);
  localparam int NLVL = 1 << PW;
  localparam logic [AW-1:0] OFF_RAW  = AW'(12'h100);
  localparam logic [AW-1:0] OFF_ACT  = AW'(12'h104);
  localparam logic [AW-1:0] OFF_MSK  = AW'(12'h108);
  localparam logic [AW-1:0] OFF_VEC  = AW'(12'h10C);
  localparam logic [AW-1:0] OFF_CUR  = AW'(12'h110);
  localparam logic [AW-1:0] OFF_EN   = AW'(12'h114);
  localparam logic [AW-1:0] OFF_SET  = AW'(12'h120);
  localparam logic [AW-1:0] OFF_CLR  = AW'(12'h124);
  localparam logic [AW-1:0] OFF_EOS  = AW'(12'h130);
  localparam logic [AW-1:0] CTRL_END = AW'(NSRC * 4);

  logic [1:0]      typ [NSRC];
  logic [PW-1:0]   pri [NSRC];
  logic [NSRC-1:0] en_q, src_q, edge_q, edge_nx, edge_set, pend, mpend, elig;
  logic [NLVL-1:0] isr_q, isr_nx;
  logic [IW-1:0]   cur_q, win, cidx;
  logic [PW-1:0]   top, best;
  logic            busy, any_elig, ack, eos, ctrl_hit, irq_q;

  assign cidx     = addr[IW+1:2];
  assign ctrl_hit = (addr < CTRL_END) && (addr[1:0] == 2'b00);
  assign ack      = rd_en && (addr == OFF_VEC) && any_elig;
  assign eos      = wr_en && (addr == OFF_EOS);
  assign busy     = |isr_q;
  assign mpend    = pend & en_q;
  assign irq_n    = irq_q;

  always_comb begin
    top = '0;
    for (int l = 0; l < NLVL; l++) if (isr_q[l]) top = PW'(l);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign pend[g]     = typ[g][1] ? edge_q[g] : (typ[g][0] ? src_in[g] : ~src_in[g]);
    assign edge_set[g] = (typ[g] == 2'b11) ? (src_in[g] & ~src_q[g]) :
                         (typ[g] == 2'b10) ? (~src_in[g] & src_q[g]) : 1'b0;
    assign elig[g]     = mpend[g] && (!busy || pri[g] > top);
  end

  always_comb begin
    any_elig = 1'b0;
    win      = '0;
    best     = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (!any_elig || pri[i] >= best)) begin
        any_elig = 1'b1;
        best     = pri[i];
        win      = IW'(i);
      end
    end
  end

  always_comb begin
    isr_nx = isr_q;
    if (eos && busy) isr_nx[top] = 1'b0;
    if (ack) isr_nx[pri[win]] = 1'b1;
    for (int i = 0; i < NSRC; i++) begin
      edge_nx[i] = edge_q[i];
      if (ack && win == IW'(i)) edge_nx[i] = 1'b0;
      if (wr_en && ctrl_hit && cidx == IW'(i)) edge_nx[i] = 1'b0;
      if (edge_set[i]) edge_nx[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      src_q  <= '0;
      edge_q <= '0;
      isr_q  <= '0;
      cur_q  <= '0;
      irq_q  <= 1'b1;
      for (int i = 0; i < NSRC; i++) begin
        typ[i] <= '0;
        pri[i] <= '0;
      end
    end else begin
      src_q  <= src_in;
      edge_q <= edge_nx;
      isr_q  <= isr_nx;
      irq_q  <= ack ? 1'b1 : ~any_elig;
      if (ack) cur_q <= win;
      if (wr_en && addr == OFF_SET) en_q <= en_q | wdata[NSRC-1:0];
      if (wr_en && addr == OFF_CLR) en_q <= en_q & ~wdata[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (wr_en && ctrl_hit && cidx == IW'(i)) begin
          typ[i] <= wdata[7:6];
          pri[i] <= wdata[PW-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[7:6]    = typ[cidx];
      rdata[PW-1:0] = pri[cidx];
    end else begin
      case (addr)
        OFF_RAW: rdata[NSRC-1:0] = src_in;
        OFF_ACT: rdata[NSRC-1:0] = pend;
        OFF_MSK: rdata[NSRC-1:0] = mpend;
        OFF_VEC: if (any_elig) rdata[IW+1:0] = {win, 2'b00};
        OFF_CUR: rdata[IW-1:0]   = cur_q;
        OFF_EN:  rdata[NSRC-1:0] = en_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int AW   = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [AW-1:0]        addr,
  input logic                 irq_n,
  input logic [NSRC-1:0]      en,
  input logic [(1<<PW)-1:0]   isr,
  input logic                 any_elig
);
  localparam logic [AW-1:0] C_VEC = AW'(12'h10C);
  localparam logic [AW-1:0] C_EOS = AW'(12'h130);

  a_r8_ack_releases_line: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_VEC && !irq_n) |=> irq_n);

  a_r3_disabled_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> irq_n);

  a_r9_eos_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_EOS && !rd_en && isr != '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1));

  a_r9_ack_adds_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_VEC && !(wr_en && addr == C_EOS) && any_elig) |=>
      ($countones(isr) == $countones($past(isr)) + 1));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .irq_n(irq_n), .en(en_q), .isr(isr_q), .any_elig(any_elig)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;
  int total = 0, bad = 0;
  logic [31:0] v;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #2 clk = ~clk;

  localparam logic [31:0] PAT [8] = '{32'h0000_0001, 32'h0000_0006, 32'h8000_0080,
    32'h0000_0110, 32'h4000_0040, 32'h0F00_0000, 32'h0000_0009, 32'h0001_0200};
  localparam int WIN [8] = '{0, 2, 7, 4, 6, 27, 3, 9};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 irq_n", {31'b0, irq_n}, 32'd1);
    rd(9'h114, v); chk("R1 enable word", v, 32'h0);
    rd(9'h000, v); chk("R1 ctrl0", v, 32'h0);
    rd(9'h07C, v); chk("R1 ctrl31", v, 32'h0);

    // R2 program all inputs high-level with priority i%8
    for (int i = 0; i < 32; i++) wr(9'(4 * i), 32'h40 | (i & 7));
    rd(9'h014, v); chk("R2 ctrl5 readback", v, 32'h45);
    rd(9'h07C, v); chk("R2 ctrl31 readback", v, 32'h47);
    wr(9'h120, 32'hFFFF_FFFF);
    rd(9'h114, v); chk("R3 all enabled", v, 32'hFFFF_FFFF);

    // R4 R7 R8 arbitration table
    for (int k = 0; k < 8; k++) begin
      src_in = PAT[k];
      idle(2);
      chk("R8 irq low", {31'b0, irq_n}, 32'd0);
      rd(9'h10C, v); chk("R4 R7 vector", v, 32'(WIN[k] * 4));
      chk("R8 irq released", {31'b0, irq_n}, 32'd1);
      rd(9'h110, v); chk("R7 current source", v, 32'(WIN[k]));
      src_in = '0;
      wr(9'h130, 32'h0);
      idle(2);
      chk("R9 idle after eos", {31'b0, irq_n}, 32'd1);
    end

    // R3 R10 disable command and status words
    wr(9'h124, 32'h0000_0080);
    rd(9'h114, v); chk("R3 enable word after clear", v, 32'hFFFF_FF7F);
    src_in = 32'h0000_0080;
    idle(2);
    chk("R3 disabled input quiet", {31'b0, irq_n}, 32'd1);
    rd(9'h100, v); chk("R10 raw", v, 32'h0000_0080);
    rd(9'h104, v); chk("R10 pending", v, 32'h0000_0080);
    rd(9'h108, v); chk("R10 masked pending", v, 32'h0);
    wr(9'h120, 32'h0000_0080);
    idle(2);
    chk("R3 re-enabled", {31'b0, irq_n}, 32'd0);
    rd(9'h10C, v); chk("R7 vector src7", v, 32'd28);
    src_in = '0;
    wr(9'h130, 32'h0);

    // R5 low level on input 5
    src_in = 32'h0000_0020;
    wr(9'h014, 32'h05);
    idle(2);
    chk("R5 low-level inactive when high", {31'b0, irq_n}, 32'd1);
    src_in = '0;
    idle(2);
    chk("R5 low-level active", {31'b0, irq_n}, 32'd0);
    rd(9'h10C, v); chk("R5 vector src5", v, 32'd20);
    src_in = 32'h0000_0020;
    wr(9'h130, 32'h0);
    wr(9'h014, 32'h45);
    src_in = '0;
    idle(2);
    chk("R5 restored quiet", {31'b0, irq_n}, 32'd1);

    // R6 falling edge on input 10
    wr(9'h028, 32'h83);
    src_in = 32'h0000_0400;
    idle(2);
    chk("R6 falling ignores rise", {31'b0, irq_n}, 32'd1);
    src_in = '0;
    idle(3);
    chk("R6 falling raises irq", {31'b0, irq_n}, 32'd0);
    rd(9'h104, v); chk("R6 falling latched", v, 32'h0000_0400);
    rd(9'h10C, v); chk("R6 vector src10", v, 32'd40);
    rd(9'h104, v); chk("R6 latch cleared by ack", v, 32'h0);
    wr(9'h130, 32'h0);
    idle(2);
    chk("R6 quiet after falling", {31'b0, irq_n}, 32'd1);

    // R6 rising edge, single-cycle pulse on input 12
    wr(9'h030, 32'hC2);
    @(negedge clk); src_in = 32'h0000_1000;
    @(negedge clk); src_in = '0;
    idle(2);
    chk("R6 rising pulse latched", {31'b0, irq_n}, 32'd0);
    rd(9'h10C, v); chk("R6 vector src12", v, 32'd48);
    rd(9'h104, v); chk("R6 rising latch cleared", v, 32'h0);
    wr(9'h130, 32'h0);
    idle(2);
    chk("R6 quiet after rising", {31'b0, irq_n}, 32'd1);

    // R9 nesting
    src_in = 32'h0000_0008;
    idle(2);
    rd(9'h10C, v); chk("R9 first vector src3", v, 32'd12);
    src_in = 32'h0000_080A;
    idle(2);
    chk("R9 equal and lower blocked", {31'b0, irq_n}, 32'd1);
    src_in = 32'h0000_088A;
    idle(2);
    chk("R9 higher preempts", {31'b0, irq_n}, 32'd0);
    rd(9'h10C, v); chk("R9 nested vector src7", v, 32'd28);
    rd(9'h110, v); chk("R7 current nested", v, 32'd7);
    src_in = 32'h0000_080A;
    wr(9'h130, 32'h0);
    idle(2);
    chk("R9 outer level still holds", {31'b0, irq_n}, 32'd1);
    wr(9'h130, 32'h0);
    idle(2);
    chk("R9 stack empty raises", {31'b0, irq_n}, 32'd0);
    rd(9'h10C, v); chk("R4 R9 tie lowest index", v, 32'd12);
    src_in = 32'h0000_0802;
    wr(9'h130, 32'h0);
    idle(2);
    rd(9'h10C, v); chk("R9 next src11", v, 32'd44);
    src_in = 32'h0000_0002;
    wr(9'h130, 32'h0);
    idle(2);
    rd(9'h10C, v); chk("R9 last src1", v, 32'd4);
    src_in = '0;
    wr(9'h130, 32'h0);
    idle(2);
    chk("R9 all retired", {31'b0, irq_n}, 32'd1);
    rd(9'h10C, v); chk("R7 empty vector", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule